// File: doc/BRIEF.md
# Configurable Pin Interrupt Detector

This block watches a group of asynchronous input pins (32 by default) and keeps one interrupt status flag per pin. Each pin has its own 4-bit trigger code, which selects whether the flag is raised by a low level, a high level, a rising edge, a falling edge or either edge. All other codes leave the pin unable to raise its flag. The pins are first brought into the clock domain through a two-flop synchronizer. An edge is found by comparing the synchronized value with the value it had one clock earlier.

The flags are set by the hardware. Software clears them by writing ones to the port-wide status view: each one clears the matching flag, and each zero leaves its flag alone. A flag is visible in two places: as its own bit of the port-wide status vector, and through a per-pin readback that also returns that pin's trigger code. One combined request output is the OR of all flags and is meant for the interrupt controller.

A level trigger that is still present when software clears the flag raises the flag again at once. If a trigger event and a clear reach the same flag in the same cycle, the event wins. The control and status pins are plain signals. The block carries no data stream, so it needs no valid/ready handshake.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset, every flag, `irq_o` and every trigger code are zero.
- R2: Trigger code 0000 (off) and every code not listed in R3 to R5 (for example 0101, 1111, 0001) never set a flag. A flag that is already set keeps its value until it is cleared.
- R3: Code 1000 sets the flag in every cycle in which the synchronized pin is 0. A flag cleared while the pin is still low is set again at that same clock edge, so it reads as still set.
- R4: Code 1100 sets the flag in every cycle in which the synchronized pin is 1.
- R5: Code 1001 sets the flag on a 0-to-1 change of the synchronized pin, code 1010 on a 1-to-0 change, and code 1011 on either change.
- R6: With `clr_en` high, each one in `clr_mask` clears the flag of the same bit index. Bits that are zero in `clr_mask` are not changed.
- R7: When a trigger event and a clear hit the same flag in one cycle, the flag ends up set.
- R8: `irq_o` is high exactly when at least one flag is set.
- R9: `rd_flag` equals the flag of pin `rd_sel`, and `rd_mode` returns that pin's trigger code. Both are combinational.
- R10: A control write (`ctl_we`, `ctl_sel`, `ctl_mode`) stores the code for one pin only. The new code takes effect from the next clock.
- R11: A pin change driven before clock edge N is visible on `flags_o` after edge N+2. This covers two synchronizer stages and one flag stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous input pins |
| ctl_we | input | 1 | Trigger-code write strobe |
| ctl_sel | input | SEL_W | Pin index for the write |
| ctl_mode | input | 4 | Trigger code to store |
| clr_en | input | 1 | Write-one-to-clear strobe for the status view |
| clr_mask | input | NPINS | Ones select the flags to clear |
| rd_sel | input | SEL_W | Pin index for the per-pin readback |
| rd_mode | output | 4 | Trigger code of pin `rd_sel` |
| rd_flag | output | 1 | Flag of pin `rd_sel` |
| flags_o | output | NPINS | Port-wide status view of all flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives a clear onto a flag in the very cycle its edge event arrives. A design that let the clear win would lose that interrupt. It also clears a level-triggered flag while the level is still held. A design that dropped the flag for one cycle, or left it dropped, would show up there. Reserved codes are programmed onto toggling pins, because a loose decoder would set flags from them. The latency is counted edge by edge, which catches a synchronizer with a missing or an extra stage. Partial clears are also checked: they must keep `irq_o` high while any other flag is still set.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int TRIG_W = 4;

  localparam logic [TRIG_W-1:0] TRIG_OFF  = 4'b0000;
  localparam logic [TRIG_W-1:0] TRIG_LOW  = 4'b1000;
  localparam logic [TRIG_W-1:0] TRIG_RISE = 4'b1001;
  localparam logic [TRIG_W-1:0] TRIG_FALL = 4'b1010;
  localparam logic [TRIG_W-1:0] TRIG_BOTH = 4'b1011;
  localparam logic [TRIG_W-1:0] TRIG_HIGH = 4'b1100;

  // Decide whether the current pin sample raises the flag under a trigger code.
  function automatic logic trig_hit(input logic [TRIG_W-1:0] code,
                                    input logic cur, input logic prev);
    logic hit;
    case (code)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      TRIG_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/pin_trig_cell.sv
module pin_trig_cell
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [TRIG_W-1:0] mode_wd,
  input  logic              sync_i,
  input  logic              clr_i,
  output logic [TRIG_W-1:0] mode_o,
  output logic              flag_o
);

  logic [TRIG_W-1:0] mode_q;
  logic              prev_q;
  logic              flag_q;
  logic              hit;

  assign hit = trig_hit(mode_q, sync_i, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= TRIG_OFF;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wd;
      prev_q <= sync_i;
      // a set event wins over a clear in the same cycle
      flag_q <= hit | (flag_q & ~clr_i);
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;

  // R2
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != TRIG_LOW && mode_q != TRIG_HIGH && mode_q != TRIG_RISE &&
     mode_q != TRIG_FALL && mode_q != TRIG_BOTH && !flag_q) |=> !flag_q);

  // R3
  low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_LOW && !sync_i) |=> flag_q);

  // R5
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_RISE && sync_i && !prev_q) |=> flag_q);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !flag_q);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit) |=> flag_q);

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              ctl_we,
  input  logic [SEL_W-1:0]  ctl_sel,
  input  logic [TRIG_W-1:0] ctl_mode,
  input  logic              clr_en,
  input  logic [NPINS-1:0]  clr_mask,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [TRIG_W-1:0] rd_mode,
  output logic              rd_flag,
  output logic [NPINS-1:0]  flags_o,
  output logic              irq_o
);

  logic [NPINS-1:0]  pin_s;
  logic [NPINS-1:0]  flag_v;
  logic [TRIG_W-1:0] mode_v [NPINS];

  pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_trig_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_we (ctl_we && (ctl_sel == SEL_W'(i))),
      .mode_wd (ctl_mode),
      .sync_i  (pin_s[i]),
      .clr_i   (clr_en && clr_mask[i]),
      .mode_o  (mode_v[i]),
      .flag_o  (flag_v[i])
    );
  end

  always_comb begin
    rd_mode = TRIG_OFF;
    rd_flag = 1'b0;
    if (int'(rd_sel) < NPINS) begin
      rd_mode = mode_v[rd_sel];
      rd_flag = flag_v[rd_sel];
    end
  end

  assign flags_o = flag_v;
  assign irq_o   = |flag_v;

  // R8
  irq_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ($countones(flags_o) != 0));

  // R6
  untouched_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

endmodule

// File: tb/tb_pin_irq_detect.sv
`timescale 1ns/1ps
module tb_pin_irq_detect;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_i;
  logic          ctl_we;
  logic [4:0]    ctl_sel;
  logic [3:0]    ctl_mode;
  logic          clr_en;
  logic [N-1:0]  clr_mask;
  logic [4:0]    rd_sel;
  logic [3:0]    rd_mode;
  logic          rd_flag;
  logic [N-1:0]  flags_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pin_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_mode(ctl_mode), .clr_en(clr_en), .clr_mask(clr_mask), .rd_sel(rd_sel),
    .rd_mode(rd_mode), .rd_flag(rd_flag), .flags_o(flags_o), .irq_o(irq_o)
  );

  // expected-value model
  logic [3:0]   m_mode [N];
  logic [N-1:0] m_s1, m_s2, m_prev, m_flag;

  function automatic logic exp_hit(input logic [3:0] c, input logic cur, input logic prv);
    if (c == 4'b1000) return !cur;
    if (c == 4'b1100) return cur;
    if (c == 4'b1001) return cur && !prv;
    if (c == 4'b1010) return !cur && prv;
    if (c == 4'b1011) return cur != prv;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_mode[i] = 4'b0000;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0;
    end else begin
      for (int i = 0; i < N; i++)
        m_flag[i] = exp_hit(m_mode[i], m_s2[i], m_prev[i]) ||
                    (m_flag[i] && !(clr_en && clr_mask[i]));
      if (ctl_we) m_mode[ctl_sel] = ctl_mode;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_model();
    check("R5 flags vs model", 64'(flags_o), 64'(m_flag));
    check("R8 irq", 64'(irq_o), 64'(m_flag != '0));
    check("R9 rd_flag", 64'(rd_flag), 64'(m_flag[rd_sel]));
    check("R10 rd_mode", 64'(rd_mode), 64'(m_mode[rd_sel]));
  endtask

  task automatic step();
    @(posedge clk); #1;
    check_model();
    @(negedge clk);
    ctl_we = 1'b0; clr_en = 1'b0; clr_mask = '0;
  endtask

  task automatic set_mode(input int p, input logic [3:0] c);
    ctl_we = 1'b1; ctl_sel = 5'(p); ctl_mode = c;
    step();
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    void'($urandom(32'd20240601));
    rst_n = 1'b0; pin_i = '0; ctl_we = 0; ctl_sel = 0; ctl_mode = 0;
    clr_en = 0; clr_mask = '0; rd_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 flags after reset", 64'(flags_o), 64'h0);
    check("R1 irq after reset", 64'(irq_o), 64'h0);
    check("R1 code after reset", 64'(rd_mode), 64'h0);

    // R4 high level with R11 latency
    set_mode(5, 4'b1100);
    rd_sel = 5'd5;
    pin_i[5] = 1'b1;
    steps(2);
    check("R11 no flag after two edges", 64'(flags_o[5]), 64'h0);
    step();
    check("R4 high level flag after third edge", 64'(flags_o[5]), 64'h1);
    check("R9 per-pin flag readback", 64'(rd_flag), 64'h1);
    // R3 level still present: clear does not drop it
    clr_en = 1'b1; clr_mask = 32'h20;
    step();
    check("R3 level re-sets after clear", 64'(flags_o[5]), 64'h1);
    pin_i[5] = 1'b0;
    steps(3);
    clr_en = 1'b1; clr_mask = 32'h20;
    step();
    check("R6 clear removes flag", 64'(flags_o[5]), 64'h0);

    // R3 low level on pin 9
    pin_i[9] = 1'b1;
    steps(3);
    set_mode(9, 4'b1000);
    steps(2);
    check("R3 no flag while high", 64'(flags_o[9]), 64'h0);
    pin_i[9] = 1'b0;
    steps(3);
    check("R3 low level sets flag", 64'(flags_o[9]), 64'h1);

    // R7 clear collides with rising event on pin 2
    set_mode(2, 4'b1001);
    pin_i[2] = 1'b1;
    steps(2);
    clr_en = 1'b1; clr_mask = 32'h4;
    step();
    check("R7 set wins over clear", 64'(flags_o[2]), 64'h1);

    // R8 partial clear keeps irq high
    clr_en = 1'b1; clr_mask = 32'h4;
    step();
    check("R6 pin2 cleared", 64'(flags_o[2]), 64'h0);
    check("R8 irq held by other flag", 64'(irq_o), 64'h1);

    // R5 falling and either edge
    set_mode(12, 4'b1010);
    set_mode(13, 4'b1011);
    pin_i[12] = 1'b1; pin_i[13] = 1'b1;
    steps(3);
    check("R5 falling ignores rise", 64'(flags_o[12]), 64'h0);
    check("R5 either catches rise", 64'(flags_o[13]), 64'h1);
    pin_i[12] = 1'b0;
    steps(3);
    check("R5 falling edge flag", 64'(flags_o[12]), 64'h1);

    // R2 reserved and off codes
    set_mode(7, 4'b0101);
    set_mode(8, 4'b1111);
    set_mode(10, 4'b0000);
    for (int k = 0; k < 6; k++) begin
      pin_i[7] = ~pin_i[7]; pin_i[8] = ~pin_i[8]; pin_i[10] = ~pin_i[10];
      steps(2);
    end
    check("R2 reserved/off codes never flag", 64'(flags_o & 32'h580), 64'h0);

    // clear all before random phase
    clr_en = 1'b1; clr_mask = '1;
    step();

    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [3:0] codes [8];
      codes = '{4'b0000, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b0110, 4'b1110};
      pin_i = pin_i ^ ($urandom() & $urandom());
      if ($urandom_range(0, 3) == 0) begin
        ctl_we = 1'b1; ctl_sel = 5'($urandom_range(0, N-1));
        ctl_mode = codes[$urandom_range(0, 7)];
      end
      if ($urandom_range(0, 2) == 0) begin
        clr_en = 1'b1; clr_mask = $urandom();
      end
      rd_sel = 5'($urandom_range(0, N-1));
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule